// File: doc/BRIEF.md
# DMA Device Exclusion Checker

This block sits in the path of memory requests started by bus-mastering devices and returns an allow or deny verdict for each one. A request carries a requester device number, a physical address, a read/write flag and a flag that marks processor-originated traffic. A programmable table assigns each device to one of four protection domains. Every domain other than domain 0 owns a bitmap with one bit per 4 KiB physical page, and the bit for the addressed page decides the verdict. Domain 0 always allows access, and processor traffic is never checked.

Software programs the block through a simple write-only configuration port. One operation sets the domain of a device. Another loads a 32-bit word of a domain's page bitmap. A third clears a sticky record of the first denied request. At reset every device is placed in domain 1 and all bitmaps are empty, so device DMA is refused until software opens pages. Devices placed in the same domain share one bitmap, so isolation is only as fine as the domain assignment.

Top module: `dxc_dma_guard`

## Requirements
- R1: Each cycle with `req_valid` high produces `rsp_valid` high on the next clock, with the verdict on `rsp_allow`. A cycle without a request gives `rsp_valid` low next cycle, and `rsp_allow` is never high while `rsp_valid` is low.
- R2: A request with `req_cpu` high is allowed whatever its device, domain or address.
- R3: A device mapped to domain 0 is allowed at any address, including pages outside the checked window.
- R4: After reset, `rsp_valid` and `flt_set` are low, every device is in domain 1, and all bitmap bits are 0, so any non-processor request is denied.
- R5: A configuration write with `cfg_op` = 0 sets the domain of device `cfg_idx[DEV_W-1:0]` to `cfg_wdata[1:0]`.
- R6: A configuration write with `cfg_op` = 1 and `cfg_dom` in 1..3 loads bitmap word `cfg_idx` of that domain. Bit j of `cfg_wdata` governs page number `cfg_idx*32 + j`, and 1 means allowed. The same write with `cfg_dom` = 0 changes nothing.
- R7: The page number is `req_addr >> 12`. Pages at or beyond the window size (4096 pages at default parameters) are denied for devices in domains 1 to 3, even if the bitmap bit at the same low page bits is 1.
- R8: Two devices mapped to the same domain receive identical verdicts for the same page.
- R9: If a configuration write and a request happen in the same cycle, the request is judged on the table and bitmap contents from before the write.
- R10: The first denied request sets `flt_set` in the same cycle its denial appears on the response outputs. It also records the device on `flt_dev` and the page number on `flt_page`. Later denials leave all three unchanged while the flag is set.
- R11: A configuration write with `cfg_op` = 2 clears `flt_set`. A denial in that same cycle is then recorded as a new first denial.
- R12: A configuration write with `cfg_op` = 3 has no effect. The `req_write` flag does not affect the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_cpu | input | 1 | Request comes from the processor and bypasses the check |
| req_dev | input | DEV_W | Requester device number |
| req_addr | input | ADDR_W | Physical byte address |
| req_write | input | 1 | 1 for write, 0 for read; does not change the verdict |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | 0 domain map, 1 bitmap word, 2 clear denial record, 3 no operation |
| cfg_dom | input | 2 | Target domain of a bitmap word write |
| cfg_idx | input | IDX_W | Device number or bitmap word index |
| cfg_wdata | input | WORD_W | Domain number (low two bits) or bitmap word |
| rsp_valid | output | 1 | Verdict is valid this cycle |
| rsp_allow | output | 1 | 1 allow, 0 deny |
| flt_set | output | 1 | Sticky: a denial has been recorded |
| flt_dev | output | DEV_W | Device of the recorded denial |
| flt_page | output | ADDR_W-12 | Page number of the recorded denial |

## Verification
The bench builds the block with a 24-bit address and a window of 128 pages. Each programmable domain then holds only four bitmap words, so random writes and requests reach every bitmap bit many times. Requests can also cross the window edge at page 128, where the low page bits alias onto allowed bits. The 32-entry device table is kept at full size, so all devices and all four domains are used. Random page numbers run past the window, so denials for out-of-window pages are exercised together with domain 0 and processor bypass.

// File: rtl/dxc_pkg.sv
package dxc_pkg;

    // Configuration operations selected by cfg_op.
    typedef enum logic [1:0] {
        CFG_MAP  = 2'd0,
        CFG_PERM = 2'd1,
        CFG_CLR  = 2'd2,
        CFG_NOP  = 2'd3
    } cfg_op_e;

    // Four protection domains, domain 0 allows everything.
    localparam int DOM_W = 2;

endpackage

// File: rtl/dxc_dom_table.sv
module dxc_dom_table #(
    parameter int DEV_W   = 5,
    parameter int DOM_W   = 2,
    parameter int RST_DOM = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DEV_W-1:0] wr_dev,
    input  logic [DOM_W-1:0] wr_dom,
    input  logic [DEV_W-1:0] rd_dev,
    output logic [DOM_W-1:0] rd_dom
);
    localparam int NDEV = 1 << DEV_W;

    logic [DOM_W-1:0] map_d [NDEV];
    logic [DOM_W-1:0] map_q [NDEV];

    always_comb begin
        map_d = map_q;
        if (wr_en) begin
            map_d[wr_dev] = wr_dom;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NDEV; i++) begin
                map_q[i] <= DOM_W'(RST_DOM);
            end
        end else begin
            map_q <= map_d;
        end
    end

    // Lookup reads the registered table, so a same-cycle write is not seen.
    assign rd_dom = map_q[rd_dev];

endmodule

// File: rtl/dxc_perm_map.sv
module dxc_perm_map #(
    parameter int DOM_W  = 2,
    parameter int PG_W   = 12,
    parameter int WORD_W = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [DOM_W-1:0]                     wr_dom,
    input  logic [PG_W-$clog2(WORD_W)-1:0]       wr_idx,
    input  logic [WORD_W-1:0]                    wr_data,
    input  logic [DOM_W-1:0]                     rd_dom,
    input  logic [PG_W-1:0]                      rd_page,
    output logic                                 rd_bit
);
    localparam int NDOM   = 1 << DOM_W;
    localparam int WSEL_W = $clog2(WORD_W);
    localparam int WIDX_W = PG_W - WSEL_W;
    localparam int NWORD  = 1 << WIDX_W;

    logic [NDOM-1:0]   bank_bit;
    logic [WIDX_W-1:0] rd_word;
    logic [WSEL_W-1:0] rd_sel;

    assign rd_word = rd_page[PG_W-1:WSEL_W];
    assign rd_sel  = rd_page[WSEL_W-1:0];

    // Domain 0 has no storage: it reads as all ones.
    assign bank_bit[0] = 1'b1;

    for (genvar d = 1; d < NDOM; d++) begin : g_bank
        logic [WORD_W-1:0] w_d [NWORD];
        logic [WORD_W-1:0] w_q [NWORD];
        logic              hit;

        assign hit = wr_en && (wr_dom == DOM_W'(d));

        always_comb begin
            w_d = w_q;
            if (hit) begin
                w_d[wr_idx] = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < NWORD; i++) begin
                    w_q[i] <= '0;
                end
            end else begin
                w_q <= w_d;
            end
        end

        assign bank_bit[d] = w_q[rd_word][rd_sel];
    end

    assign rd_bit = bank_bit[rd_dom];

endmodule

// File: rtl/dxc_fault_latch.sv
module dxc_fault_latch #(
    parameter int DEV_W = 5,
    parameter int PN_W  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hit,
    input  logic [DEV_W-1:0] hit_dev,
    input  logic [PN_W-1:0]  hit_page,
    output logic             set,
    output logic [DEV_W-1:0] dev,
    output logic [PN_W-1:0]  page
);
    typedef struct packed {
        logic             set;
        logic [DEV_W-1:0] dev;
        logic [PN_W-1:0]  page;
    } rec_t;

    rec_t rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        // Clear first, so a denial in the clearing cycle is kept.
        if (clr) begin
            rec_d.set = 1'b0;
        end
        if (hit && !rec_d.set) begin
            rec_d.set  = 1'b1;
            rec_d.dev  = hit_dev;
            rec_d.page = hit_page;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_q <= '0;
        end else begin
            rec_q <= rec_d;
        end
    end

    assign set  = rec_q.set;
    assign dev  = rec_q.dev;
    assign page = rec_q.page;

endmodule

// File: rtl/dxc_dma_guard.sv
module dxc_dma_guard #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int WIN_PG_W   = 12,
    parameter int DEV_W      = 5,
    parameter int WORD_W     = 32,
    parameter int IDX_W      = (DEV_W > WIN_PG_W - $clog2(WORD_W)) ?
                               DEV_W : WIN_PG_W - $clog2(WORD_W)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_cpu,
    input  logic [DEV_W-1:0]             req_dev,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic                         req_write,
    input  logic                         cfg_valid,
    input  logic [1:0]                   cfg_op,
    input  logic [1:0]                   cfg_dom,
    input  logic [IDX_W-1:0]             cfg_idx,
    input  logic [WORD_W-1:0]            cfg_wdata,
    output logic                         rsp_valid,
    output logic                         rsp_allow,
    output logic                         flt_set,
    output logic [DEV_W-1:0]             flt_dev,
    output logic [ADDR_W-PAGE_SHIFT-1:0] flt_page
);
    import dxc_pkg::*;

    localparam int PN_W   = ADDR_W - PAGE_SHIFT;
    localparam int WIDX_W = WIN_PG_W - $clog2(WORD_W);

    typedef struct packed {
        logic valid;
        logic allow;
    } rsp_t;

    cfg_op_e           op;
    logic              map_we, perm_we, clr_flag;
    logic [PN_W-1:0]   page;
    logic [DOM_W-1:0]  dom;
    logic              perm_bit;
    logic              in_win;
    logic              allow_c;
    logic              deny_c;
    rsp_t              rsp_d, rsp_q;
    logic              unused_ok;

    // Configuration decode.
    assign op       = cfg_op_e'(cfg_op);
    assign map_we   = cfg_valid && (op == CFG_MAP);
    assign perm_we  = cfg_valid && (op == CFG_PERM);
    assign clr_flag = cfg_valid && (op == CFG_CLR);

    assign page = req_addr[ADDR_W-1:PAGE_SHIFT];

    dxc_dom_table #(
        .DEV_W  (DEV_W),
        .DOM_W  (DOM_W),
        .RST_DOM(1)
    ) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (map_we),
        .wr_dev(cfg_idx[DEV_W-1:0]),
        .wr_dom(cfg_wdata[DOM_W-1:0]),
        .rd_dev(req_dev),
        .rd_dom(dom)
    );

    dxc_perm_map #(
        .DOM_W (DOM_W),
        .PG_W  (WIN_PG_W),
        .WORD_W(WORD_W)
    ) u_perm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (perm_we),
        .wr_dom (cfg_dom),
        .wr_idx (cfg_idx[WIDX_W-1:0]),
        .wr_data(cfg_wdata),
        .rd_dom (dom),
        .rd_page(page[WIN_PG_W-1:0]),
        .rd_bit (perm_bit)
    );

    // Pages above the checked window have no bitmap bits.
    if (PN_W > WIN_PG_W) begin : g_win
        assign in_win = ~|page[PN_W-1:WIN_PG_W];
    end else begin : g_full
        assign in_win = 1'b1;
    end

    always_comb begin
        allow_c = req_cpu || (dom == DOM_W'(0)) || (in_win && perm_bit);
        deny_c  = req_valid && !allow_c;

        rsp_d.valid = req_valid;
        rsp_d.allow = req_valid && allow_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_allow = rsp_q.allow;

    dxc_fault_latch #(
        .DEV_W(DEV_W),
        .PN_W (PN_W)
    ) u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_flag),
        .hit     (deny_c),
        .hit_dev (req_dev),
        .hit_page(page),
        .set     (flt_set),
        .dev     (flt_dev),
        .page    (flt_page)
    );

    // Offset bits and the direction flag play no part in the verdict.
    assign unused_ok = ^{req_addr[PAGE_SHIFT-1:0], req_write};

endmodule

// File: rtl/dxc_dma_guard_chk.sv
module dxc_dma_guard_chk #(
    parameter int DEV_W = 5,
    parameter int PN_W  = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_cpu,
    input logic             cfg_valid,
    input logic [1:0]       cfg_op,
    input logic             rsp_valid,
    input logic             rsp_allow,
    input logic             flt_set,
    input logic [DEV_W-1:0] flt_dev,
    input logic [PN_W-1:0]  flt_page
);
    logic clr_now;
    assign clr_now = cfg_valid && (cfg_op == 2'd2);

    a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r1_allow_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_allow |-> rsp_valid);

    a_r2_cpu_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cpu) |=> rsp_allow);

    a_r10_deny_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_allow) |-> flt_set);

    a_r10_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_set && !clr_now) |=> (flt_set && $stable(flt_dev) && $stable(flt_page)));

    a_r11_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_now && !(req_valid && !req_cpu)) |=> !flt_set);

endmodule

bind dxc_dma_guard dxc_dma_guard_chk #(
    .DEV_W(DEV_W),
    .PN_W (PN_W)
) u_chk (.*);

// File: tb/dxc_dma_guard_test.sv
module dxc_dma_guard_test;

    localparam int ADDR_W     = 24;
    localparam int PAGE_SHIFT = 12;
    localparam int WIN_PG_W   = 7;
    localparam int DEV_W      = 5;
    localparam int WORD_W     = 32;
    localparam int IDX_W      = 5;
    localparam int PN_W       = ADDR_W - PAGE_SHIFT;
    localparam int NPG        = 1 << WIN_PG_W;
    localparam int NDEV       = 1 << DEV_W;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                req_valid, req_cpu, req_write;
    logic [DEV_W-1:0]    req_dev;
    logic [ADDR_W-1:0]   req_addr;
    logic                cfg_valid;
    logic [1:0]          cfg_op, cfg_dom;
    logic [IDX_W-1:0]    cfg_idx;
    logic [WORD_W-1:0]   cfg_wdata;
    logic                rsp_valid, rsp_allow, flt_set;
    logic [DEV_W-1:0]    flt_dev;
    logic [PN_W-1:0]     flt_page;

    always #5 clk = ~clk;

    dxc_dma_guard #(
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT),
        .WIN_PG_W  (WIN_PG_W),
        .DEV_W     (DEV_W),
        .WORD_W    (WORD_W),
        .IDX_W     (IDX_W)
    ) uut (.*);

    // Reference state built from the requirements.
    logic [1:0]      m_map  [NDEV];
    logic            m_perm [4][NPG];
    logic            m_flag;
    int              m_fdev;
    int              m_fpg;
    int              n_chk = 0;
    int              n_bad = 0;
    bit              done  = 1'b0;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_allow(bit cpu, int dev, logic [ADDR_W-1:0] addr);
        int pg = int'(addr >> PAGE_SHIFT);
        int d  = int'(m_map[dev]);
        if (cpu) return 1'b1;
        if (d == 0) return 1'b1;
        if (pg >= NPG) return 1'b0;
        return m_perm[d][pg];
    endfunction

    // One cycle: drive at the falling edge, check after the next rising edge.
    task automatic step(string tag, bit rv, bit cpu, int dev, int pg, bit wr,
                        bit cv, int op, int cdom, int cidx, logic [31:0] cdata);
        bit e_valid, e_allow;
        req_valid = rv;  req_cpu = cpu; req_dev = DEV_W'(dev);
        req_addr  = ADDR_W'((pg << PAGE_SHIFT) | ($urandom % 4096));
        req_write = wr;
        cfg_valid = cv;  cfg_op = 2'(op); cfg_dom = 2'(cdom);
        cfg_idx   = IDX_W'(cidx); cfg_wdata = cdata;

        e_valid = rv;
        e_allow = rv && exp_allow(cpu, dev, req_addr);

        if (cv && op == 2) m_flag = 1'b0;
        if (rv && !e_allow && !m_flag) begin
            m_flag = 1'b1; m_fdev = dev; m_fpg = int'(req_addr >> PAGE_SHIFT);
        end
        if (cv && op == 0) m_map[cidx % NDEV] = cdata[1:0];
        if (cv && op == 1 && cdom != 0)
            for (int j = 0; j < 32; j++) m_perm[cdom][((cidx % 4) * 32 + j)] = cdata[j];

        @(posedge clk);
        #1;
        chk(tag, "rsp_valid", int'(rsp_valid), int'(e_valid));
        if (e_valid) chk(tag, "rsp_allow", int'(rsp_allow), int'(e_allow));
        chk(tag, "flt_set", int'(flt_set), int'(m_flag));
        if (m_flag) begin
            chk(tag, "flt_dev", int'(flt_dev), m_fdev);
            chk(tag, "flt_page", int'(flt_page), m_fpg);
        end
        @(negedge clk);
    endtask

    task automatic req(string tag, bit cpu, int dev, int pg, bit wr = 1'b0);
        step(tag, 1'b1, cpu, dev, pg, wr, 1'b0, 3, 0, 0, 32'h0);
    endtask

    task automatic cfg(string tag, int op, int cdom, int cidx, logic [31:0] d);
        step(tag, 1'b0, 1'b0, 0, 0, 1'b0, 1'b1, op, cdom, cidx, d);
    endtask

    task automatic wrap_up();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        wrap_up();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NDEV; i++) m_map[i] = 2'd1;
        for (int d = 0; d < 4; d++)
            for (int p = 0; p < NPG; p++) m_perm[d][p] = (d == 0);
        m_flag = 1'b0; m_fdev = 0; m_fpg = 0;

        rst_n = 1'b0;
        req_valid = 0; req_cpu = 0; req_dev = '0; req_addr = '0; req_write = 0;
        cfg_valid = 0; cfg_op = '0; cfg_dom = '0; cfg_idx = '0; cfg_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R4 reset state
        chk("R4", "rsp_valid", int'(rsp_valid), 0);
        chk("R4", "flt_set", int'(flt_set), 0);

        req("R4", 0, 3, 0);                       // denied, records dev 3 page 0
        req("R10", 0, 7, 5);                      // second denial, record kept
        req("R2", 1, 7, 200);                     // processor bypass
        cfg("R12", 3, 1, 0, 32'hFFFF_FFFF);       // no-op must not open pages
        req("R12", 0, 3, 0);
        cfg("R11", 2, 0, 0, 32'h0);               // clear record
        step("R11", 1, 0, 12, 9, 0, 1, 2, 0, 0, 32'h0); // clear + denial together
        cfg("R11", 2, 0, 0, 32'h0);
        cfg("R6", 1, 1, 0, 32'h0000_0021);        // pages 0 and 5 of domain 1
        req("R6", 0, 3, 0);
        req("R6", 0, 3, 5);
        req("R6", 0, 3, 1);
        cfg("R6", 1, 0, 0, 32'h0);                // domain 0 write ignored
        req("R6", 0, 3, 0);
        step("R9", 1, 0, 3, 1, 0, 1, 1, 1, 0, 32'h0000_0023); // old bitmap used
        req("R9", 0, 3, 1);
        step("R9", 1, 0, 9, 0, 0, 1, 0, 0, 9, 32'h2);         // old domain used
        req("R5", 0, 9, 0);                       // domain 2 is empty
        cfg("R5", 0, 0, 9, 32'h0);
        req("R3", 0, 9, 200);                     // domain 0 outside window
        cfg("R8", 0, 0, 10, 32'h1);
        req("R8", 0, 10, 5);
        req("R8", 0, 10, 2);
        cfg("R7", 1, 1, 3, 32'h8000_0000);        // page 127 of domain 1
        req("R7", 0, 3, NPG - 1);
        req("R7", 0, 3, NPG);                     // aliases page 0, still denied
        req("R12", 0, 10, 5, 1'b1);               // write flag: same verdict
        cfg("R11", 2, 0, 0, 32'h0);

        for (int n = 0; n < 4000; n++) begin
            int op = $urandom % 4;
            int cidx = (op == 0) ? ($urandom % NDEV) : ($urandom % 4);
            logic [31:0] cd = (op == 0) ? 32'($urandom % 4) : $urandom;
            if (op == 2 && ($urandom % 4) != 0) op = 3;
            step("R1", ($urandom % 8) != 0, ($urandom % 8) == 0, $urandom % NDEV,
                 $urandom % (NPG + 32), $urandom % 2,
                 ($urandom % 3) == 0, op, $urandom % 4, cidx, cd);
        end

        wrap_up();
    end

endmodule